// File: doc/BRIEF.md
# I2C Bus Condition Monitor

This block watches the clock and data lines of a two-wire serial bus and recognises the two framing conditions that open and close a transfer. It keeps a flag saying whether the bus is currently in use. A recognised opening condition sets the flag and a recognised closing condition clears it. Each kind of condition also sets its own sticky status bit.

Software reaches the block through a minimal write port. One selector value loads a two-bit enable mask. The other selector value clears status bits, where each bit written as one clears the matching status bit. The status bits, their masked versions, a combined interrupt and the busy flag are all visible as plain outputs.

The line inputs are asynchronous to the block clock and are resynchronised inside the block. Address matching, data shifting and driving the bus belong to other blocks.

Top module: `i2c_cond_mon`

## Requirements
- R1: After reset, `raw_stat`, `mask_q`, `irq` and `bus_busy` are all zero.
- R2: A start condition is detected when SDA goes 1 to 0 between two consecutive synchronized samples while SCL is 1 in both samples. It sets `raw_stat[0]` and `bus_busy`, visible `SYNC_STAGES+1` clock edges after the inputs change.
- R3: A stop condition is detected when SDA goes 0 to 1 between two consecutive synchronized samples while SCL is 1 in both samples. It sets `raw_stat[1]` and clears `bus_busy`, with the same latency as R2.
- R4: The following change neither status bit nor `bus_busy`:
  - an SDA change while SCL is 0 in either sample;
  - any SCL change while SDA is steady.
- R5: A start condition seen while `bus_busy` is 1 (a repeated start) sets `raw_stat[0]` and leaves `bus_busy` at 1.
- R6: Status bits are sticky. A write with `reg_sel`=1 clears each status bit whose `reg_wdata` bit is 1; bit 0 is start and bit 1 is stop. Bits written as 0 are unchanged.
- R7: If a condition is detected in the same cycle as a clear of its status bit, the bit ends up set.
- R8: A write with `reg_sel`=0 loads `reg_wdata` into `mask_q`. `masked_stat` is `raw_stat & mask_q` and `irq` is the OR of `masked_stat`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line, asynchronous |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0: load mask, 1: clear status |
| reg_wdata | input | 2 | Write data; bit 0 start, bit 1 stop |
| raw_stat | output | 2 | Sticky status; bit 0 start, bit 1 stop |
| mask_q | output | 2 | Current interrupt mask |
| masked_stat | output | 2 | Status gated by the mask |
| irq | output | 1 | OR of masked status |
| bus_busy | output | 1 | Bus in use flag |

## Verification
A change on the lines reaches `raw_stat` and `bus_busy` `SYNC_STAGES+1` rising edges later. The mask reaches `mask_q`, `masked_stat` and `irq` one edge after its write, and a clear takes effect one edge after its write.

The bench holds every line pattern for `SYNC_STAGES+2` cycles before it samples, so each result is already settled. It applies writes alone and samples at the following falling edge.

For the set-versus-clear collision, the bench places the clear write on exactly the `SYNC_STAGES+1`-th edge after the line change, so that it meets the detection.

// File: rtl/i2c_cond_mon.sv
module i2c_cond_mon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic       reg_we,
  input  logic       reg_sel,
  input  logic [1:0] reg_wdata,
  output logic [1:0] raw_stat,
  output logic [1:0] mask_q,
  output logic [1:0] masked_stat,
  output logic       irq,
  output logic       bus_busy
);

  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_s, sda_s, scl_p, sda_p;
  logic start_det, stop_det;
  logic [1:0] clr_vec, set_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_in};
      sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_in};
      scl_p  <= scl_s;
      sda_p  <= sda_s;
    end
  end

  assign scl_s = scl_sh[SYNC_STAGES-1];
  assign sda_s = sda_sh[SYNC_STAGES-1];

  assign start_det = scl_p & scl_s &  sda_p & ~sda_s;
  assign stop_det  = scl_p & scl_s & ~sda_p &  sda_s;

  assign set_vec = {stop_det, start_det};
  assign clr_vec = (reg_we && reg_sel) ? reg_wdata : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_stat <= 2'b00;
      mask_q   <= 2'b00;
      bus_busy <= 1'b0;
    end else begin
      raw_stat <= (raw_stat & ~clr_vec) | set_vec;
      if (reg_we && !reg_sel) mask_q <= reg_wdata;
      if (start_det)     bus_busy <= 1'b1;
      else if (stop_det) bus_busy <= 1'b0;
    end
  end

  assign masked_stat = raw_stat & mask_q;
  assign irq         = |masked_stat;

endmodule

// File: rtl/i2c_cond_mon_chk.sv
module i2c_cond_mon_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_det,
  input logic       stop_det,
  input logic       reg_we,
  input logic       reg_sel,
  input logic [1:0] reg_wdata,
  input logic [1:0] raw_stat,
  input logic [1:0] mask_q,
  input logic       bus_busy
);

  p_start_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> raw_stat[0] && bus_busy);

  p_stop_frees_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> raw_stat[1] && !bus_busy);

  p_no_spurious_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !start_det |=> !(raw_stat[0] && !$past(raw_stat[0])));

  p_busy_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_det && !stop_det) |=> $stable(bus_busy));

  p_restart_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && bus_busy) |=> bus_busy);

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_stat[1] && !(reg_we && reg_sel && reg_wdata[1])) |=> raw_stat[1]);

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && reg_we && reg_sel && reg_wdata[0]) |=> raw_stat[0]);

  p_mask_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !reg_sel) |=> mask_q == $past(reg_wdata));

endmodule

bind i2c_cond_mon i2c_cond_mon_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_det(start_det), .stop_det(stop_det),
  .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
  .raw_stat(raw_stat), .mask_q(mask_q), .bus_busy(bus_busy)
);

// File: tb/sim_i2c_cond_mon.sv
module sim_i2c_cond_mon;
  localparam int STG = 2;
  localparam int HOLD = STG + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_in = 1'b1, sda_in = 1'b1;
  logic reg_we = 1'b0, reg_sel = 1'b0;
  logic [1:0] reg_wdata = 2'b00;
  logic [1:0] raw_stat, mask_q, masked_stat;
  logic irq, bus_busy;

  int vecs = 0, errs = 0;
  logic [1:0] e_raw = 2'b00, e_mask = 2'b00;
  logic e_busy = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;

  always #4 clk = ~clk;

  i2c_cond_mon #(.SYNC_STAGES(STG)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .raw_stat(raw_stat), .mask_q(mask_q), .masked_stat(masked_stat),
    .irq(irq), .bus_busy(bus_busy)
  );

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R2 R3 R6 raw"}, raw_stat, e_raw);
    chk({tag, " R2 R3 R5 busy"}, {1'b0, bus_busy}, {1'b0, e_busy});
    chk({tag, " R8 mask"}, mask_q, e_mask);
    chk({tag, " R8 masked"}, masked_stat, e_raw & e_mask);
    chk({tag, " R8 irq"}, {1'b0, irq}, {1'b0, |(e_raw & e_mask)});
  endtask

  // Expected effect of a line change, per R2 to R5
  function automatic logic [1:0] events(input logic ps, input logic pd, input logic s, input logic d);
    return {ps & s & ~pd & d, ps & s & pd & ~d};
  endfunction

  task automatic lines(input logic s, input logic d);
    logic [1:0] ev;
    @(negedge clk);
    scl_in = s; sda_in = d;
    ev = events(m_scl, m_sda, s, d);
    m_scl = s; m_sda = d;
    e_raw = e_raw | ev;
    if (ev[0]) e_busy = 1'b1;
    else if (ev[1]) e_busy = 1'b0;
    repeat (HOLD) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (sel) e_raw = e_raw & ~d;
    else e_mask = d;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check_all("reset R1");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_all("after reset R1");

    lines(1'b1, 1'b0);
    check_all("start R2");

    lines(1'b0, 1'b0);
    lines(1'b0, 1'b1);
    lines(1'b0, 1'b0);
    check_all("sda while scl low R4");

    lines(1'b0, 1'b1);
    lines(1'b1, 1'b1);
    lines(1'b1, 1'b0);
    check_all("repeated start R5");

    wr(1'b1, 2'b10);
    check_all("clear stop only R6");
    wr(1'b1, 2'b01);
    check_all("clear start R6");

    lines(1'b0, 1'b0);
    lines(1'b1, 1'b0);
    lines(1'b1, 1'b1);
    check_all("stop R3");

    wr(1'b0, 2'b10);
    check_all("mask stop R8");
    wr(1'b0, 2'b01);
    check_all("mask start R8");

    // Collision: start detection meets a clear of bit 0
    wr(1'b1, 2'b11);
    @(negedge clk);
    sda_in = 1'b0;
    m_sda = 1'b0;
    repeat (STG) @(posedge clk);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 1'b1; reg_wdata = 2'b01;
    @(negedge clk);
    reg_we = 1'b0;
    e_raw = 2'b01;
    e_busy = 1'b1;
    repeat (HOLD) @(negedge clk);
    check_all("set beats clear R7");

    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op < 7) begin
        lines(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      end else begin
        wr(op == 9, 2'($urandom_range(0, 3)));
      end
      check_all("random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule